// File: doc/BRIEF.md
# Reflected CRC-16 Payload Checker

This block computes a 16-bit checksum over a stream of payload bytes using the polynomial x^16+x^12+x^5+1 in bit-reflected form, starting from zero. When the payload closes, it swaps the two bytes of the result and compares the swapped value with a 16-bit checksum that the peripheral reports. It pulses a done strobe and raises either an ok flag or an error flag. A host sequencer feeds the bytes it exchanged with the peripheral into the block. It fetches the peripheral's checksum register (offset 0x44) over the bus and presents that value on `periph_crc` in the cycle that closes the payload.

Bytes enter over a valid/ready handshake. The block never applies back-pressure: `in_ready` is high in every cycle, including during reset, so a byte is consumed in each cycle where `in_valid` is high. The `in_start` and `in_last` strobes are sideband controls that act in any cycle, whether or not `in_valid` is high. Within a single cycle, the start is applied first, then the byte, then the close. For this reason an empty payload is written as `in_start` and `in_last` together, with `in_valid` low.

During initialisation the sequencer must write the code presented on `csum_enable_code` (0x01) to the peripheral's checksum-enable register at offset 0x40. The peripheral does not produce checksums until that write is made.

Top module: `crc16r_checker`

## Requirements
- R1: After reset, `crc_out` is 0x0000, `done`, `match_ok` and `match_err` are 0, and no payload is open. Bytes are ignored until the first start.
- R2: A cycle with `in_start` high sets the running CRC to 0x0000 and clears `match_ok` and `match_err`. If that cycle carries no byte, `crc_out` reads 0x0000 on the next cycle.
- R3: Each accepted byte of an open payload updates the CRC bitwise. Bits are taken from bit 0 upward. For each bit, feedback = crc[0] XOR data bit; crc is shifted right by one; if the feedback is 1, crc is XORed with 0x8408. No final XOR is applied, and `crc_out` shows the raw, unswapped running value.
- R4: Within one cycle the order is start, then byte, then close. A cycle with `in_start` and `in_last` high and `in_valid` low closes an empty payload, whose result is 0x0000.
- R5: `done` is high for exactly the one cycle after the edge that takes a close (`in_last` while a payload is open or being started). In that cycle `crc_out` holds the final CRC.
- R6: At close, the block compares {crc[7:0], crc[15:8]} with `periph_crc` as sampled in the closing cycle. On equality `match_ok`=1 and `match_err`=0; otherwise `match_ok`=0 and `match_err`=1.
- R7: After a close, `crc_out`, `match_ok` and `match_err` hold until the next start. Bytes and `in_last` strobes that arrive while no payload is open have no effect.
- R8: A start that arrives while a payload is open discards the partial CRC. The result then covers only the bytes from that start onward.
- R9: `in_ready` is 1 in every cycle.
- R10: `csum_enable_code` carries 0x01, the byte the sequencer writes to the peripheral's checksum-enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload byte present |
| in_ready | output | 1 | Byte accepted when high with in_valid (always high) |
| in_data | input | 8 | Payload byte |
| in_start | input | 1 | Begin a new payload, clearing the CRC |
| in_last | input | 1 | Close the current payload |
| periph_crc | input | 16 | Checksum reported by the peripheral, valid in the closing cycle |
| crc_out | output | 16 | Raw running or final CRC |
| done | output | 1 | One-cycle pulse after a close |
| match_ok | output | 1 | Swapped result equalled periph_crc |
| match_err | output | 1 | Swapped result differed from periph_crc |
| csum_enable_code | output | 8 | Byte to write to the peripheral's checksum-enable register |

## Verification
The assertions assume that `in_start`, `in_last` and `in_valid` are known (never X) while reset is released. They also assume that a close is the only event that can raise `done`, so the verdict flags may change only after a start or at a done. The stimulus drives every control input to a defined 0 or 1 from time zero, changes inputs only on the falling clock edge, and holds `periph_crc` steady across each closing cycle. Random idle gaps, stray bytes and stray closes after a close, and an abandoned partial payload exercise the hold and restart rules without ever leaving a control input undefined.

// File: rtl/crc16r_pkg.sv
package crc16r_pkg;
  localparam int unsigned CRC_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam logic [CRC_W-1:0] POLY_REFL = 16'h8408;
  localparam logic [BYTE_W-1:0] ENABLE_CODE = 8'h01;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic crc_t swap_bytes(input crc_t v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/crc16r_step.sv
module crc16r_step
  import crc16r_pkg::*;
#(
  parameter int unsigned CW   = CRC_W,
  parameter int unsigned DW   = BYTE_W,
  parameter logic [CW-1:0] POLY = POLY_REFL
) (
  input  logic [CW-1:0] crc_in,
  input  logic [DW-1:0] data_in,
  output logic [CW-1:0] crc_next
);
  logic [CW-1:0] stage [0:DW];

  assign stage[0] = crc_in;

  for (genvar g = 0; g < DW; g++) begin : g_bit
    logic fb;
    assign fb = stage[g][0] ^ data_in[g];
    assign stage[g+1] = (stage[g] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_next = stage[DW];
endmodule

// File: rtl/crc16r_accum.sv
module crc16r_accum
  import crc16r_pkg::*;
#(
  parameter int unsigned CW = CRC_W,
  parameter int unsigned DW = BYTE_W,
  parameter logic [CW-1:0] POLY = POLY_REFL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          beat,
  input  logic          last,
  input  logic [DW-1:0] data,
  output logic [CW-1:0] crc_q,
  output logic [CW-1:0] crc_final,
  output logic          close_evt
);
  logic          open_q;
  logic          active;
  logic [CW-1:0] base;
  logic [CW-1:0] stepped;
  logic [CW-1:0] nxt;

  crc16r_step #(.CW(CW), .DW(DW), .POLY(POLY)) u_step (
    .crc_in  (base),
    .data_in (data),
    .crc_next(stepped)
  );

  always_comb begin
    active    = start | open_q;
    base      = start ? '0 : crc_q;
    nxt       = (active && beat) ? stepped : base;
    close_evt = active & last;
    crc_final = nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= '0;
      open_q <= 1'b0;
    end else begin
      if (active) crc_q <= nxt;
      if (start)       open_q <= !last;
      else if (open_q) open_q <= !last;
    end
  end
endmodule

// File: rtl/crc16r_judge.sv
module crc16r_judge
  import crc16r_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic close_evt,
  input  crc_t crc_final,
  input  crc_t periph_crc,
  output logic done,
  output logic ok,
  output logic err
);
  logic same;

  assign same = (swap_bytes(crc_final) == periph_crc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      ok   <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= close_evt;
      if (close_evt) begin
        ok  <= same;
        err <= !same;
      end else if (start) begin
        ok  <= 1'b0;
        err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/crc16r_checker.sv
module crc16r_checker
  import crc16r_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_start,
  input  logic        in_last,
  input  logic [15:0] periph_crc,
  output logic [15:0] crc_out,
  output logic        done,
  output logic        match_ok,
  output logic        match_err,
  output logic [7:0]  csum_enable_code
);
  crc_t crc_final;
  logic close_evt;
  logic beat;

  assign in_ready         = 1'b1;
  assign beat             = in_valid & in_ready;
  assign csum_enable_code = ENABLE_CODE;

  crc16r_accum u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (in_start),
    .beat     (beat),
    .last     (in_last),
    .data     (in_data),
    .crc_q    (crc_out),
    .crc_final(crc_final),
    .close_evt(close_evt)
  );

  crc16r_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (in_start),
    .close_evt (close_evt),
    .crc_final (crc_final),
    .periph_crc(periph_crc),
    .done      (done),
    .ok        (match_ok),
    .err       (match_err)
  );
endmodule

// File: rtl/crc16r_checker_sva.sv
module crc16r_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_start,
  input logic        in_last,
  input logic [15:0] crc_out,
  input logic        done,
  input logic        match_ok,
  input logic        match_err
);
  AST_START_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_start && !in_valid) |-> crc_out == 16'h0000); // R2

  AST_START_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_start && !in_last) |-> (!match_ok && !match_err)); // R2

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_last)); // R5

  AST_VERDICT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({match_ok, match_err})); // R6

  AST_CRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_start) && !$past(in_valid)) |-> $stable(crc_out)); // R7

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_start) && !done) |-> ($stable(match_ok) && $stable(match_err))); // R7
endmodule

bind crc16r_checker crc16r_checker_sva u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_start (in_start),
  .in_last  (in_last),
  .crc_out  (crc_out),
  .done     (done),
  .match_ok (match_ok),
  .match_err(match_err)
);

// File: tb/tb_crc16r_checker.sv
module tb_crc16r_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        in_start = 1'b0;
  logic        in_last = 1'b0;
  logic [15:0] periph_crc = 16'h0000;
  logic [15:0] crc_out;
  logic        done;
  logic        match_ok;
  logic        match_err;
  logic [7:0]  csum_enable_code;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] mem [0:63];

  always #5 clk = ~clk;

  crc16r_checker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_start(in_start), .in_last(in_last),
    .periph_crc(periph_crc), .crc_out(crc_out), .done(done),
    .match_ok(match_ok), .match_err(match_err),
    .csum_enable_code(csum_enable_code)
  );

  function automatic logic [15:0] model(input int len);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < len; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ mem[i][b];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  task automatic check(input bit cond, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
  endtask

  task automatic run_payload(input int len, input bit good, input int gap_pct,
                             input string tag);
    logic [15:0] exp;
    logic [15:0] refv;
    exp  = model(len);
    refv = good ? {exp[7:0], exp[15:8]} : ({exp[7:0], exp[15:8]} ^ 16'h0010);
    periph_crc = refv;
    if (len == 0) begin
      in_start = 1'b1; in_last = 1'b1; in_valid = 1'b0;
      @(negedge clk);
    end else begin
      for (int i = 0; i < len; i++) begin
        while (($urandom % 100) < gap_pct) begin
          idle();
          @(negedge clk);
        end
        in_valid = 1'b1; in_data = mem[i];
        in_start = (i == 0); in_last = (i == len - 1);
        @(negedge clk);
      end
    end
    idle();
    check(done === 1'b1, {tag, " R5 done"}, {15'd0, done}, 16'd1);
    check(crc_out === exp, {tag, " R3 crc"}, crc_out, exp);
    check(match_ok === good && match_err === !good, {tag, " R6 verdict"},
          {14'd0, match_ok, match_err}, {14'd0, good, !good});
    in_valid = 1'b1; in_data = 8'hA5; in_last = 1'b1;
    @(negedge clk);
    idle();
    check(done === 1'b0, {tag, " R5/R7 no second done"}, {15'd0, done}, 16'd0);
    check(crc_out === exp, {tag, " R7 crc held"}, crc_out, exp);
    check(match_ok === good && match_err === !good, {tag, " R7 flags held"},
          {14'd0, match_ok, match_err}, {14'd0, good, !good});
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'd0, 16'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (5) @(negedge clk);
    check(in_ready === 1'b1, "R9 ready in reset", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(crc_out === 16'h0000 && done === 1'b0 && match_ok === 1'b0 && match_err === 1'b0,
          "R1 reset state", crc_out, 16'h0000);
    check(csum_enable_code === 8'h01, "R10 enable code", {8'd0, csum_enable_code}, 16'h0001);
    // R1: bytes before any start are ignored
    in_valid = 1'b1; in_data = 8'h5A; in_last = 1'b1;
    @(negedge clk);
    idle();
    check(crc_out === 16'h0000 && done === 1'b0, "R1 byte before start ignored",
          crc_out, 16'h0000);
    check(in_ready === 1'b1, "R9 ready", {15'd0, in_ready}, 16'd1);

    // R4: empty payload, then length 1 and 64
    run_payload(0, 1'b1, 0, "len0 R4");
    mem[0] = 8'h01;
    run_payload(1, 1'b1, 0, "len1");
    mem[0] = 8'h00;
    run_payload(1, 1'b0, 0, "len1 zero byte mismatch");
    for (int i = 0; i < 64; i++) mem[i] = 8'(i * 37 + 11);
    run_payload(64, 1'b1, 20, "len64");
    for (int i = 0; i < 64; i++) mem[i] = 8'hFF;
    run_payload(64, 1'b0, 0, "len64 ones mismatch");

    // R2: a lone start zeroes crc and clears the flags
    in_start = 1'b1;
    @(negedge clk);
    idle();
    check(crc_out === 16'h0000, "R2 start zeroes crc", crc_out, 16'h0000);
    check(match_ok === 1'b0 && match_err === 1'b0, "R2 start clears flags",
          {14'd0, match_ok, match_err}, 16'd0);

    // R8: abandon a partial payload, restart
    in_valid = 1'b1; in_data = 8'h3C;
    @(negedge clk);
    in_data = 8'hC3;
    @(negedge clk);
    idle();
    for (int i = 0; i < 5; i++) mem[i] = 8'(8'h10 + i);
    run_payload(5, 1'b1, 30, "R8 restart");

    // random payloads
    for (int t = 0; t < 12; t++) begin
      int len;
      len = 2 + int'($urandom % 62);
      for (int i = 0; i < len; i++) mem[i] = 8'($urandom);
      run_payload(len, bit'($urandom % 2), 25, "rand R3");
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule